// File: doc/BRIEF.md
# Adaptive Peak-Tracking Switchpoint Detector

This block turns a stream of signed samples of a differential sensor signal into a one-bit square wave. The square wave follows the teeth of a rotating target. The block keeps a tracked high peak and a tracked low peak. From these two peaks it derives an operate threshold high in the span and a release threshold low in the span. The output goes to its post-operate state when the signal climbs above the operate threshold. It returns when the signal drops below the release threshold. The band between the two thresholds is the hysteresis.

Each peak is refreshed once per signal edge. The high peak is taken from the largest sample of the high phase that has just ended. The low peak is taken from the smallest sample of the low phase that has just ended. Because the thresholds always come from the two most recent opposite peaks, slow amplitude drift is followed edge by edge.

A new, larger extreme takes effect at once. A shrinking peak may move toward the centre only by a bounded step at each edge, so one weak tooth cannot collapse the switching band. There is no time-based decay, so the output holds its state for as long as the target stands still.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is always high, and every cycle with `in_valid` high delivers exactly one sample. The mode-control pins `enable` and `blank` are plain levels. While either one freezes the output, peak tracking carries on.

Top module: `peak_switchpoint`

## Requirements
- R1: After reset, `out_state` is 0 and both strobes are 0. The peaks start at +256 (high) and -256 (low), which gives `op_thresh` = 96 and `rp_thresh` = -104.
- R2: `op_thresh` equals low peak + sum of (span >> k) over the set bits of OP_FRAC. OP_FRAC bit 7 weighs 1/2 and bit 0 weighs 1/256. The span is the high peak minus the low peak. The default is 1/2 + 1/8 + 1/16.
- R3: `rp_thresh` equals low peak + sum of (span >> k) over the set bits of RP_FRAC, using the same weighting as R2. The default is 1/4 + 1/32 + 1/64.
- R4: When `out_state` is 0 and an accepted sample is strictly greater than `op_thresh` while the block is not frozen, `out_state` becomes 1 on that clock edge.
- R5: When `out_state` is 1 and an accepted sample is strictly less than `rp_thresh` while the block is not frozen, `out_state` becomes 0 on that clock edge.
- R6: Accepted samples that do not meet R4 or R5 leave `out_state` unchanged.
- R7: An accepted sample above the high peak, or below the low peak, replaces that peak on the same edge. Both thresholds reflect the new peak from the next cycle on.
- R8: At a peak update, a peak moves inward by at most span >> STEP_SHIFT (default 4) of the span held before that edge.
- R9: At a release edge, the high peak takes the limited maximum of the high phase. At an operate edge, the low peak takes the limited minimum of the low phase.
- R10: While `enable` is 0 or `blank` is 1, `out_state` and the strobes stay unchanged. Peaks and running extremes keep updating.
- R11: With no accepted sample, or with a constant sample value after at most one edge, `out_state` and both thresholds hold indefinitely.
- R12: `pos_peak_stb` is high for exactly the one cycle after a release edge. `neg_peak_stb` is high for exactly the one cycle after an operate edge.
- R13: `in_ready` is always 1, and each cycle with `in_valid` high consumes one sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample present on the stream |
| in_ready | output | 1 | Always 1, so no back-pressure |
| in_sample | input | W (12) | Two's-complement sample |
| enable | input | 1 | Switching allowed by the mode controller |
| blank | input | 1 | Lockout: holds the output when high |
| out_state | output | 1 | Switched output, 1 after an operate crossing |
| op_thresh | output | W (12) | Current operate threshold, signed |
| rp_thresh | output | W (12) | Current release threshold, signed |
| pos_peak_stb | output | 1 | High peak captured (release edge) |
| neg_peak_stb | output | 1 | Low peak captured (operate edge) |

## Verification
The bench sweeps triangle waves over many amplitudes, offsets and strides, including the full 12-bit range. A design that lost the guard bit there would wrap its span and place thresholds outside the peaks. Decaying amplitude sequences catch a peak that jumps straight to the shrunken value instead of stepping inward, which would show as a threshold moving more than one step per edge. Growing sequences catch outward moves that are delayed until the next edge. Frozen and blanked sweeps catch an output that toggles during lockout, or trackers that stop while the output is held. Long idle and constant-input stretches catch any hidden decay or spurious toggling at zero speed.

// File: rtl/pksw_pkg.sv
package pksw_pkg;
  // Number of binary fraction bits used for the threshold ratios.
  localparam int FRAC_W = 8;

  // Output phase: low after a release crossing, high after an operate crossing.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/pksw_thresh.sv
module pksw_thresh
  import pksw_pkg::*;
#(
  parameter int W = 12,
  parameter logic [FRAC_W-1:0] OP_FRAC = 8'hB0,
  parameter logic [FRAC_W-1:0] RP_FRAC = 8'h4C
) (
  input  logic signed [W-1:0] hi_pk,
  input  logic signed [W-1:0] lo_pk,
  output logic        [W:0]   span,
  output logic signed [W-1:0] op_th,
  output logic signed [W-1:0] rp_th
);
  localparam int XW = W + 2;

  logic signed [W:0]  diff;
  logic        [W:0]  op_acc [0:FRAC_W];
  logic        [W:0]  rp_acc [0:FRAC_W];
  logic signed [XW-1:0] op_full, rp_full;

  // The span needs one guard bit beyond the sample width.
  assign diff = (W+1)'(hi_pk) - (W+1)'(lo_pk);
  assign span = $unsigned(diff);

  assign op_acc[0] = '0;
  assign rp_acc[0] = '0;

  // Shift-and-add scaling: fraction bit FRAC_W-1-k weighs 2^-(k+1).
  for (genvar k = 0; k < FRAC_W; k++) begin : g_term
    assign op_acc[k+1] = op_acc[k] + (OP_FRAC[FRAC_W-1-k] ? (span >> (k+1)) : '0);
    assign rp_acc[k+1] = rp_acc[k] + (RP_FRAC[FRAC_W-1-k] ? (span >> (k+1)) : '0);
  end

  assign op_full = XW'(lo_pk) + $signed({1'b0, op_acc[FRAC_W]});
  assign rp_full = XW'(lo_pk) + $signed({1'b0, rp_acc[FRAC_W]});
  assign op_th   = W'(op_full);
  assign rp_th   = W'(rp_full);
endmodule

// File: rtl/pksw_peak.sv
module pksw_peak #(
  parameter int W      = 12,
  parameter bit IS_MAX = 1'b1,
  parameter int INIT   = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc,
  input  logic signed [W-1:0] x,
  input  logic               collect,
  input  logic               start,
  input  logic               latch,
  input  logic        [W:0]  step,
  output logic signed [W-1:0] pk
);
  localparam int XW = W + 2;
  typedef logic signed [XW-1:0] ext_t;

  // Pick the value further outward for this tracker's polarity.
  function automatic ext_t pick(ext_t a, ext_t b);
    if (IS_MAX) return (a > b) ? a : b;
    else        return (a < b) ? a : b;
  endfunction

  logic signed [W-1:0] run;
  ext_t pk_e, x_e, run_e, step_e, pk_in, mid, nxt;

  always_comb begin
    pk_e   = ext_t'(pk);
    x_e    = ext_t'(x);
    run_e  = ext_t'(run);
    step_e = $signed({1'b0, step});
    // Furthest inward the peak may go in one update.
    pk_in  = IS_MAX ? (pk_e - step_e) : (pk_e + step_e);
    mid    = latch ? pick(run_e, pk_in) : pk_e;
    nxt    = acc ? pick(mid, x_e) : mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pk  <= W'(INIT);
      run <= W'(INIT);
    end else begin
      pk <= W'(nxt);
      if (acc) begin
        if (start)        run <= x;
        else if (collect) run <= W'(pick(run_e, x_e));
      end
    end
  end

  if (IS_MAX) begin : g_chk_max
    // R8: the high peak never falls by more than one step at an update
    a_r8_inward_bound: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> ext_t'(pk) >= $past(pk_in));
    // R7: a larger sample is adopted on the same edge
    a_r7_outward: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> pk >= $past(x));
  end else begin : g_chk_min
    // R8: the low peak never rises by more than one step at an update
    a_r8_inward_bound: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> ext_t'(pk) <= $past(pk_in));
    // R7: a smaller sample is adopted on the same edge
    a_r7_outward: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> pk <= $past(x));
  end
endmodule

// File: rtl/peak_switchpoint.sv
module peak_switchpoint
  import pksw_pkg::*;
#(
  parameter int W          = 12,
  parameter int STEP_SHIFT = 4,
  parameter logic [FRAC_W-1:0] OP_FRAC = 8'hB0,
  parameter logic [FRAC_W-1:0] RP_FRAC = 8'h4C,
  parameter int INIT_POS   = 256,
  parameter int INIT_NEG   = -256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic signed [W-1:0] in_sample,
  input  logic               enable,
  input  logic               blank,
  output logic               out_state,
  output logic signed [W-1:0] op_thresh,
  output logic signed [W-1:0] rp_thresh,
  output logic               pos_peak_stb,
  output logic               neg_peak_stb
);
  logic signed [W-1:0] pos_pk, neg_pk;
  logic        [W:0]   span, step;
  logic                acc, live, op_edge, rl_edge;
  phase_e              phase;

  // Samples are never held back.
  assign in_ready = 1'b1;
  assign acc      = in_valid;
  assign live     = enable & ~blank;
  assign phase    = phase_e'(out_state);
  assign step     = span >> STEP_SHIFT;

  assign op_edge = acc & live & (phase == PH_LOW)  & (in_sample > op_thresh);
  assign rl_edge = acc & live & (phase == PH_HIGH) & (in_sample < rp_thresh);

  pksw_thresh #(.W(W), .OP_FRAC(OP_FRAC), .RP_FRAC(RP_FRAC)) u_thresh (
    .hi_pk (pos_pk),
    .lo_pk (neg_pk),
    .span  (span),
    .op_th (op_thresh),
    .rp_th (rp_thresh)
  );

  // High peak: collected while high, restarted at operate, taken at release.
  pksw_peak #(.W(W), .IS_MAX(1'b1), .INIT(INIT_POS)) u_hi (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .x       (in_sample),
    .collect (phase == PH_HIGH),
    .start   (op_edge),
    .latch   (rl_edge),
    .step    (step),
    .pk      (pos_pk)
  );

  // Low peak: collected while low, restarted at release, taken at operate.
  pksw_peak #(.W(W), .IS_MAX(1'b0), .INIT(INIT_NEG)) u_lo (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .x       (in_sample),
    .collect (phase == PH_LOW),
    .start   (rl_edge),
    .latch   (op_edge),
    .step    (step),
    .pk      (neg_pk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_state    <= 1'b0;
      pos_peak_stb <= 1'b0;
      neg_peak_stb <= 1'b0;
    end else begin
      if (op_edge)      out_state <= 1'b1;
      else if (rl_edge) out_state <= 1'b0;
      pos_peak_stb <= rl_edge;
      neg_peak_stb <= op_edge;
    end
  end

  // R4: a rise needs an accepted, unfrozen sample above the operate point
  a_r4_operate_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_state) |-> $past(in_valid && enable && !blank && (in_sample > op_thresh)));
  // R5: a fall needs an accepted, unfrozen sample below the release point
  a_r5_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_state) |-> $past(in_valid && enable && !blank && (in_sample < rp_thresh)));
  // R10: a frozen cycle leaves the output alone
  a_r10_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || blank) |=> $stable(out_state));
  // R11: no sample, no change to output or thresholds
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_state) && $stable(op_thresh) && $stable(rp_thresh)));
  // R12: strobes are exclusive and follow the matching output edge
  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pos_peak_stb, neg_peak_stb}));
  a_r12_strobe_pos: assert property (@(posedge clk) disable iff (!rst_n)
    pos_peak_stb |-> $fell(out_state));
  // R3: both thresholds stay between the tracked peaks
  a_r3_in_span: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_thresh >= neg_pk) && (op_thresh <= pos_pk));
  // R2: the operate point lies above the release point
  a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
    op_thresh >= rp_thresh);
endmodule

// File: tb/sim_peak_switchpoint.sv
module sim_peak_switchpoint;
  localparam int W   = 12;
  localparam int SH  = 4;
  localparam int OPF = 8'hB0;
  localparam int RPF = 8'h4C;
  localparam int IP  = 256;
  localparam int IN  = -256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, enable, blank;
  logic in_ready, out_state, pos_peak_stb, neg_peak_stb;
  logic signed [W-1:0] in_sample, op_thresh, rp_thresh;

  peak_switchpoint #(.W(W), .STEP_SHIFT(SH), .OP_FRAC(8'hB0), .RP_FRAC(8'h4C),
                     .INIT_POS(IP), .INIT_NEG(IN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .enable(enable), .blank(blank), .out_state(out_state),
    .op_thresh(op_thresh), .rp_thresh(rp_thresh),
    .pos_peak_stb(pos_peak_stb), .neg_peak_stb(neg_peak_stb));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_pos, m_neg, m_rmax, m_rmin;
  bit m_out;

  function automatic int frac(int span, int f);
    int s = 0;
    for (int k = 1; k <= 8; k++) if (f[8-k]) s += span >> k;
    return s;
  endfunction
  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction
  function automatic int imin(int a, int b); return (a < b) ? a : b; endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(int xs, bit v, bit en_i, bit bl_i, string tag);
    int x, span, step, op, rp, mid;
    bit oe, re, nout;
    string otag;
    x = imin(2047, imax(-2048, xs));
    @(negedge clk);
    in_valid = v; in_sample = W'(x); enable = en_i; blank = bl_i;
    span = m_pos - m_neg;
    step = span >> SH;
    op = m_neg + frac(span, OPF);
    rp = m_neg + frac(span, RPF);
    oe = v && en_i && !bl_i && !m_out && (x > op);
    re = v && en_i && !bl_i && m_out && (x < rp);
    if (v) begin
      mid = re ? imax(m_rmax, m_pos - step) : m_pos;
      m_pos = imax(mid, x);
      mid = oe ? imin(m_rmin, m_neg + step) : m_neg;
      m_neg = imin(mid, x);
      if (oe) m_rmax = x; else if (m_out) m_rmax = imax(m_rmax, x);
      if (re) m_rmin = x; else if (!m_out) m_rmin = imin(m_rmin, x);
    end
    nout = oe ? 1'b1 : (re ? 1'b0 : m_out);
    otag = (nout && !m_out) ? "R4" : ((!nout && m_out) ? "R5" : "R6");
    m_out = nout;
    @(posedge clk); #2;
    span = m_pos - m_neg;
    chk({otag, " out_state ", tag}, int'(out_state), int'(m_out));
    chk({"R2 op_thresh ", tag}, int'(op_thresh), m_neg + frac(span, OPF));
    chk({"R3 rp_thresh ", tag}, int'(rp_thresh), m_neg + frac(span, RPF));
    chk({"R12 pos_peak_stb ", tag}, int'(pos_peak_stb), int'(re));
    chk({"R12 neg_peak_stb ", tag}, int'(neg_peak_stb), int'(oe));
    chk("R13 in_ready", int'(in_ready), 1);
  endtask

  task automatic tri_wave(int lo, int hi, int stride, bit en_i, bit bl_i, string tag);
    for (int v = lo; v < hi; v += stride) push(v, 1'b1, en_i, bl_i, tag);
    for (int v = hi; v > lo; v -= stride) push(v, 1'b1, en_i, bl_i, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; enable = 1'b1; blank = 1'b0;
    m_pos = IP; m_neg = IN; m_rmax = IP; m_rmin = IN; m_out = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 out_state", int'(out_state), 0);
    chk("R1 op_thresh", int'(op_thresh), 96);
    chk("R1 rp_thresh", int'(rp_thresh), -104);
    chk("R1 pos_peak_stb", int'(pos_peak_stb), 0);
    chk("R1 neg_peak_stb", int'(neg_peak_stb), 0);
    // R9 symmetric sweeps over several amplitudes and strides
    for (int a = 300; a <= 2100; a += 450)
      for (int s = 11; s <= 41; s += 15) tri_wave(-a, a, s, 1'b1, 1'b0, "R9");
    // R2 offset sweeps
    tri_wave(-100, 900, 19, 1'b1, 1'b0, "R2");
    tri_wave(-1700, -300, 23, 1'b1, 1'b0, "R2");
    // full-range sweep exercises the guard bit
    tri_wave(-2048, 2047, 61, 1'b1, 1'b0, "R9");
    // R8 decaying amplitude: peaks step inward by bounded amounts
    for (int a = 2000; a >= 200; a -= 200) tri_wave(-a, a, 23, 1'b1, 1'b0, "R8");
    // R7 growing amplitude: outward moves are immediate
    for (int a = 200; a <= 2000; a += 300) tri_wave(-a, a, 29, 1'b1, 1'b0, "R7");
    // R10 freeze by enable, then by blank; tracking continues
    tri_wave(-1800, 1800, 31, 1'b0, 1'b0, "R10");
    tri_wave(-600, 600, 17, 1'b1, 1'b1, "R10");
    tri_wave(-400, 400, 13, 1'b1, 1'b0, "R10");
    // R11 idle stream with wild sample values, then a constant input
    for (int i = 0; i < 30; i++) push((i % 2) ? 2047 : -2048, 1'b0, 1'b1, 1'b0, "R11");
    for (int i = 0; i < 40; i++) push(700, 1'b1, 1'b1, 1'b0, "R11");
    for (int i = 0; i < 40; i++) push(-700, 1'b1, 1'b1, 1'b0, "R11");
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule